// File: doc/BRIEF.md
# UART Channel Mode Router and Line Configuration

This block sits between the host side of a serial port and its bit-level receiver and transmitter. It holds the port's control, mode and bit-rate registers, turns the control bits into per-direction enable levels, a break request and one-cycle reset strobes for each direction. It forwards bytes to the receive queue and to the transmit path according to the channel mode currently selected. FIFO storage and bit serialization live in neighbouring blocks.

The mode register also sets the character format. From it the block derives the number of data bits, whether parity is used and of which sense, the stop bit count and the total frame length in bits. It also produces a bit-rate tick from the input clock, an optional divide-by-eight prescaler, and the product of a generator value and a divider value plus one.

Top module: `uart_mode_router`

## Requirements
- R1: After reset the control register holds 0x128 and the mode register holds 0. With those values both directions are disabled, break is off, the channel mode is normal, and the format is 8 data bits, even parity and 2 stop bits (a frame of 12 bits). The generator value is 15 and the divider value is 0, so the bit tick repeats every 15 cycles.
- R2: Writing the control register (select 0) with bit 0 set gives a receiver reset strobe, and with bit 1 set a transmitter reset strobe. The strobe is high for exactly the one cycle after the write and then falls by itself.
- R3: Receive is enabled exactly when control bit 2 is 1 and control bit 3 is 0.
- R4: Transmit is enabled exactly when control bit 4 is 1 and control bit 5 is 0.
- R5: The break request is high exactly when control bit 7 is 1 and control bit 8 is 0. Control bit 6 is presented as the timeout-restart level.
- R6: In normal mode (mode register select 1, bits 9:8 = 0), a line byte goes to the receive queue if receive is enabled, and a host byte goes to the transmit path if transmit is enabled. Each output is valid for one cycle, one cycle after its input.
- R7: In echo mode (bits 9:8 = 1), a line byte goes to the receive queue if receive is enabled and also to the transmit path if transmit is enabled. Host bytes are dropped.
- R8: In local loopback (bits 9:8 = 2), a host byte goes to the receive queue if receive is enabled. Line bytes are dropped and nothing reaches the transmit path.
- R9: In remote loopback (bits 9:8 = 3), a line byte goes to the transmit path if transmit is enabled. Host bytes are dropped and nothing reaches the receive queue.
- R10: Mode bits 2:1 set the data bits (3 gives 6, 2 gives 7, other values give 8). Bits 5:3 set parity (0 even, 1 odd, other values none). Bits 7:6 set the stop bits (3 gives 1, other values give 2).
- R11: The frame length equals 1 + data bits + 1 when parity is on + stop bits.
- R12: The bit tick repeats every P × G × (D + 1) cycles. P is 8 when mode bit 0 is 1 and 1 otherwise, G is the generator value (select 2) and D is the divider value (select 3).
- R13: When the generator value is 0 the bit tick never rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr_en | input | 1 | Register write strobe |
| cfg_wr_sel | input | 2 | Register select: 0 control, 1 mode, 2 generator, 3 divider |
| cfg_wr_data | input | DATA_W | Register write value |
| host_wr_valid | input | 1 | Host data byte present |
| host_wr_byte | input | BYTE_W | Host data byte |
| line_rx_valid | input | 1 | Byte received from the line |
| line_rx_byte | input | BYTE_W | Received byte |
| rxq_valid | output | 1 | Byte for the receive queue |
| rxq_byte | output | BYTE_W | Receive queue byte |
| txq_valid | output | 1 | Byte for the transmit path |
| txq_byte | output | BYTE_W | Transmit path byte |
| rx_enabled | output | 1 | Receive direction active |
| tx_enabled | output | 1 | Transmit direction active |
| break_req | output | 1 | Break requested on the line |
| timeout_restart | output | 1 | Timeout-restart control level |
| rx_reset_pulse | output | 1 | One-cycle receiver reset |
| tx_reset_pulse | output | 1 | One-cycle transmitter reset |
| chan_mode | output | 2 | Current channel mode |
| char_bits | output | 4 | Data bits per character |
| parity_on | output | 1 | Parity bit present |
| parity_odd | output | 1 | Parity sense is odd |
| stop_count | output | 2 | Stop bits per character |
| frame_bits | output | 4 | Total bits per frame |
| bit_tick | output | 1 | Bit-rate tick |

## Verification
On every cycle the assertions check the following: the reset strobes follow the control writes one cycle later and never linger; no byte leaves on a direction that was disabled in the cycle before; local loopback never feeds the transmit path and remote loopback never feeds the receive queue; echo copies one byte to both sides; and the format outputs stay in their legal ranges. The exact enable and break decode over all 512 control values and the routing table over every mode, enable pair and input mix can only be shown by the bench's sweeps. The same holds for the format decode over every mode value and for the measured tick periods, including the silent zero divisor.

// File: rtl/uart_mode_pkg.sv
package uart_mode_pkg;

    typedef enum logic [1:0] {
        CH_NORMAL = 2'd0,
        CH_ECHO   = 2'd1,
        CH_LOCAL  = 2'd2,
        CH_REMOTE = 2'd3
    } chan_mode_e;

    localparam logic [1:0] SEL_CTRL = 2'd0;
    localparam logic [1:0] SEL_MODE = 2'd1;
    localparam logic [1:0] SEL_BRG  = 2'd2;
    localparam logic [1:0] SEL_BDIV = 2'd3;

    localparam int CTRL_W = 9;
    localparam int MODE_W = 10;

    localparam int CB_RX_RST = 0;
    localparam int CB_TX_RST = 1;
    localparam int CB_RX_EN  = 2;
    localparam int CB_RX_DIS = 3;
    localparam int CB_TX_EN  = 4;
    localparam int CB_TX_DIS = 5;
    localparam int CB_TMO    = 6;
    localparam int CB_BRK_ON = 7;
    localparam int CB_BRK_OFF = 8;

    localparam logic [CTRL_W-1:0] CTRL_RESET = 9'h128;
    localparam int PRESCALE = 8;

endpackage

// File: rtl/uart_ctrl_regs.sv
module uart_ctrl_regs
    import uart_mode_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int BRG_W  = 16,
    parameter int BDIV_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    output logic              rx_en,
    output logic              tx_en,
    output logic              brk,
    output logic              tmo,
    output logic              rx_rst,
    output logic              tx_rst,
    output chan_mode_e        mode,
    output logic              div8,
    output logic [3:0]        data_bits,
    output logic              par_en,
    output logic              par_odd,
    output logic [1:0]        stop_bits,
    output logic [3:0]        frame_len,
    output logic [BRG_W-1:0]  brg,
    output logic [BDIV_W-1:0] bdiv,
    output logic              cfg_chg
);

    typedef struct packed {
        logic [CTRL_W-1:0] ctrl;
        logic [MODE_W-1:0] mode;
        logic [BRG_W-1:0]  brg;
        logic [BDIV_W-1:0] bdiv;
        logic              rx_rst;
        logic              tx_rst;
        logic              cfg_chg;
    } regs_t;

    regs_t s_d, s_q;

    always_comb begin
        s_d         = s_q;
        s_d.rx_rst  = 1'b0;
        s_d.tx_rst  = 1'b0;
        s_d.cfg_chg = 1'b0;
        if (wr_en) begin
            unique case (wr_sel)
                SEL_CTRL: begin
                    s_d.ctrl = wr_data[CTRL_W-1:0];
                    s_d.rx_rst = wr_data[CB_RX_RST];
                    s_d.tx_rst = wr_data[CB_TX_RST];
                    s_d.ctrl[CB_RX_RST] = 1'b0;
                    s_d.ctrl[CB_TX_RST] = 1'b0;
                end
                SEL_MODE: begin
                    s_d.mode = wr_data[MODE_W-1:0];
                    s_d.cfg_chg = 1'b1;
                end
                SEL_BRG: begin
                    s_d.brg = wr_data[BRG_W-1:0];
                    s_d.cfg_chg = 1'b1;
                end
                default: begin
                    s_d.bdiv = wr_data[BDIV_W-1:0];
                    s_d.cfg_chg = 1'b1;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{ctrl: CTRL_RESET, mode: '0, brg: BRG_W'(15), bdiv: '0,
                     rx_rst: 1'b0, tx_rst: 1'b0, cfg_chg: 1'b0};
        end else begin
            s_q <= s_d;
        end
    end

    always_comb begin
        rx_en  = s_q.ctrl[CB_RX_EN] & ~s_q.ctrl[CB_RX_DIS];
        tx_en  = s_q.ctrl[CB_TX_EN] & ~s_q.ctrl[CB_TX_DIS];
        brk    = s_q.ctrl[CB_BRK_ON] & ~s_q.ctrl[CB_BRK_OFF];
        tmo    = s_q.ctrl[CB_TMO];
        rx_rst = s_q.rx_rst;
        tx_rst = s_q.tx_rst;
        mode   = chan_mode_e'(s_q.mode[9:8]);
        div8   = s_q.mode[0];
        unique case (s_q.mode[2:1])
            2'd3:    data_bits = 4'd6;
            2'd2:    data_bits = 4'd7;
            default: data_bits = 4'd8;
        endcase
        par_en    = (s_q.mode[5:3] <= 3'd1);
        par_odd   = (s_q.mode[5:3] == 3'd1);
        stop_bits = (s_q.mode[7:6] == 2'd3) ? 2'd1 : 2'd2;
        frame_len = 4'd1 + data_bits + {3'b000, par_en} + {2'b00, stop_bits};
        brg     = s_q.brg;
        bdiv    = s_q.bdiv;
        cfg_chg = s_q.cfg_chg;
    end

endmodule

// File: rtl/uart_chan_router.sv
module uart_chan_router
    import uart_mode_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  chan_mode_e        mode,
    input  logic              rx_en,
    input  logic              tx_en,
    input  logic              host_valid,
    input  logic [BYTE_W-1:0] host_byte,
    input  logic              line_valid,
    input  logic [BYTE_W-1:0] line_byte,
    output logic              rxp_valid,
    output logic [BYTE_W-1:0] rxp_byte,
    output logic              txp_valid,
    output logic [BYTE_W-1:0] txp_byte
);

    typedef struct packed {
        logic              rx_v;
        logic [BYTE_W-1:0] rx_b;
        logic              tx_v;
        logic [BYTE_W-1:0] tx_b;
    } route_t;

    route_t r_d, r_q;

    always_comb begin
        r_d      = r_q;
        r_d.rx_v = 1'b0;
        r_d.tx_v = 1'b0;
        unique case (mode)
            CH_NORMAL: begin
                if (line_valid && rx_en) begin
                    r_d.rx_v = 1'b1;
                    r_d.rx_b = line_byte;
                end
                if (host_valid && tx_en) begin
                    r_d.tx_v = 1'b1;
                    r_d.tx_b = host_byte;
                end
            end
            CH_ECHO: begin
                if (line_valid && rx_en) begin
                    r_d.rx_v = 1'b1;
                    r_d.rx_b = line_byte;
                end
                if (line_valid && tx_en) begin
                    r_d.tx_v = 1'b1;
                    r_d.tx_b = line_byte;
                end
            end
            CH_LOCAL: begin
                if (host_valid && rx_en) begin
                    r_d.rx_v = 1'b1;
                    r_d.rx_b = host_byte;
                end
            end
            default: begin
                if (line_valid && tx_en) begin
                    r_d.tx_v = 1'b1;
                    r_d.tx_b = line_byte;
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign rxp_valid = r_q.rx_v;
    assign rxp_byte  = r_q.rx_b;
    assign txp_valid = r_q.tx_v;
    assign txp_byte  = r_q.tx_b;

endmodule

// File: rtl/uart_baud_tick.sv
module uart_baud_tick
    import uart_mode_pkg::*;
#(
    parameter int BRG_W  = 16,
    parameter int BDIV_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              div8,
    input  logic [BRG_W-1:0]  brg,
    input  logic [BDIV_W-1:0] bdiv,
    input  logic              restart,
    output logic              tick
);

    localparam int DIV_W = BRG_W + BDIV_W + 1;
    localparam int PRE_W = $clog2(PRESCALE);

    typedef struct packed {
        logic [PRE_W-1:0] pre;
        logic [DIV_W-1:0] cnt;
        logic             tick;
    } tick_t;

    tick_t t_d, t_q;
    logic [DIV_W-1:0] divisor;
    logic             step;

    always_comb begin
        divisor = DIV_W'(brg) * (DIV_W'(bdiv) + DIV_W'(1));
        step    = !div8 || (t_q.pre == PRE_W'(PRESCALE - 1));
        t_d      = t_q;
        t_d.tick = 1'b0;
        if (restart) begin
            t_d.pre = '0;
            t_d.cnt = '0;
        end else begin
            if (div8) begin
                t_d.pre = t_q.pre + PRE_W'(1);
            end
            if (step) begin
                if (divisor == '0) begin
                    t_d.cnt = '0;
                end else if (t_q.cnt >= divisor - DIV_W'(1)) begin
                    t_d.cnt  = '0;
                    t_d.tick = 1'b1;
                end else begin
                    t_d.cnt = t_q.cnt + DIV_W'(1);
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            t_q <= '0;
        end else begin
            t_q <= t_d;
        end
    end

    assign tick = t_q.tick;

endmodule

// File: rtl/uart_mode_router.sv
module uart_mode_router
    import uart_mode_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int BYTE_W = 8,
    parameter int BRG_W  = 16,
    parameter int BDIV_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr_en,
    input  logic [1:0]        cfg_wr_sel,
    input  logic [DATA_W-1:0] cfg_wr_data,
    input  logic              host_wr_valid,
    input  logic [BYTE_W-1:0] host_wr_byte,
    input  logic              line_rx_valid,
    input  logic [BYTE_W-1:0] line_rx_byte,
    output logic              rxq_valid,
    output logic [BYTE_W-1:0] rxq_byte,
    output logic              txq_valid,
    output logic [BYTE_W-1:0] txq_byte,
    output logic              rx_enabled,
    output logic              tx_enabled,
    output logic              break_req,
    output logic              timeout_restart,
    output logic              rx_reset_pulse,
    output logic              tx_reset_pulse,
    output logic [1:0]        chan_mode,
    output logic [3:0]        char_bits,
    output logic              parity_on,
    output logic              parity_odd,
    output logic [1:0]        stop_count,
    output logic [3:0]        frame_bits,
    output logic              bit_tick
);

    chan_mode_e        mode_w;
    logic              div8_w;
    logic [BRG_W-1:0]  brg_w;
    logic [BDIV_W-1:0] bdiv_w;
    logic              cfg_chg_w;

    uart_ctrl_regs #(.DATA_W(DATA_W), .BRG_W(BRG_W), .BDIV_W(BDIV_W)) regs_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (cfg_wr_en),
        .wr_sel    (cfg_wr_sel),
        .wr_data   (cfg_wr_data),
        .rx_en     (rx_enabled),
        .tx_en     (tx_enabled),
        .brk       (break_req),
        .tmo       (timeout_restart),
        .rx_rst    (rx_reset_pulse),
        .tx_rst    (tx_reset_pulse),
        .mode      (mode_w),
        .div8      (div8_w),
        .data_bits (char_bits),
        .par_en    (parity_on),
        .par_odd   (parity_odd),
        .stop_bits (stop_count),
        .frame_len (frame_bits),
        .brg       (brg_w),
        .bdiv      (bdiv_w),
        .cfg_chg   (cfg_chg_w)
    );

    uart_chan_router #(.BYTE_W(BYTE_W)) route_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode       (mode_w),
        .rx_en      (rx_enabled),
        .tx_en      (tx_enabled),
        .host_valid (host_wr_valid),
        .host_byte  (host_wr_byte),
        .line_valid (line_rx_valid),
        .line_byte  (line_rx_byte),
        .rxp_valid  (rxq_valid),
        .rxp_byte   (rxq_byte),
        .txp_valid  (txq_valid),
        .txp_byte   (txq_byte)
    );

    uart_baud_tick #(.BRG_W(BRG_W), .BDIV_W(BDIV_W)) tick_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .div8    (div8_w),
        .brg     (brg_w),
        .bdiv    (bdiv_w),
        .restart (cfg_chg_w),
        .tick    (bit_tick)
    );

    assign chan_mode = mode_w;

endmodule

// File: rtl/uart_mode_router_chk.sv
module uart_mode_router_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       wr_rx_rst,
    input logic       wr_tx_rst,
    input logic       rx_reset_pulse,
    input logic       tx_reset_pulse,
    input logic       rxq_valid,
    input logic       txq_valid,
    input logic [7:0] rxq_low,
    input logic [7:0] txq_low,
    input logic       rx_enabled,
    input logic       tx_enabled,
    input logic [1:0] chan_mode,
    input logic [3:0] char_bits,
    input logic [3:0] frame_bits
);

    p_rx_strobe_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_rx_rst |=> rx_reset_pulse);
    p_rx_strobe_once_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_rx_rst |=> !rx_reset_pulse);
    p_tx_strobe_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_tx_rst |=> tx_reset_pulse);
    p_tx_strobe_once_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_tx_rst |=> !tx_reset_pulse);
    p_rx_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rxq_valid |-> $past(rx_enabled));
    p_tx_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
        txq_valid |-> $past(tx_enabled));
    p_echo_copy_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rxq_valid && txq_valid && $past(chan_mode) == 2'd1) |-> (rxq_low == txq_low));
    p_local_no_tx_r8: assert property (@(posedge clk) disable iff (!rst_n)
        txq_valid |-> ($past(chan_mode) != 2'd2));
    p_remote_no_rx_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rxq_valid |-> ($past(chan_mode) != 2'd3));
    p_char_range_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (char_bits >= 4'd6) && (char_bits <= 4'd8));
    p_frame_range_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_bits >= 4'd8) && (frame_bits <= 4'd12));

endmodule

bind uart_mode_router uart_mode_router_chk chk_i (
    .clk            (clk),
    .rst_n          (rst_n),
    .wr_rx_rst      (cfg_wr_en && (cfg_wr_sel == 2'd0) && cfg_wr_data[0]),
    .wr_tx_rst      (cfg_wr_en && (cfg_wr_sel == 2'd0) && cfg_wr_data[1]),
    .rx_reset_pulse (rx_reset_pulse),
    .tx_reset_pulse (tx_reset_pulse),
    .rxq_valid      (rxq_valid),
    .txq_valid      (txq_valid),
    .rxq_low        (rxq_byte[7:0]),
    .txq_low        (txq_byte[7:0]),
    .rx_enabled     (rx_enabled),
    .tx_enabled     (tx_enabled),
    .chan_mode      (chan_mode),
    .char_bits      (char_bits),
    .frame_bits     (frame_bits)
);

// File: tb/uart_mode_router_tb_top.sv
`timescale 1ns/1ps
module uart_mode_router_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr_en = 1'b0;
    logic [1:0]  cfg_wr_sel = 2'd0;
    logic [15:0] cfg_wr_data = 16'd0;
    logic        host_wr_valid = 1'b0;
    logic [7:0]  host_wr_byte = 8'd0;
    logic        line_rx_valid = 1'b0;
    logic [7:0]  line_rx_byte = 8'd0;
    logic        rxq_valid, txq_valid;
    logic [7:0]  rxq_byte, txq_byte;
    logic        rx_enabled, tx_enabled, break_req, timeout_restart;
    logic        rx_reset_pulse, tx_reset_pulse;
    logic [1:0]  chan_mode;
    logic [3:0]  char_bits;
    logic        parity_on, parity_odd;
    logic [1:0]  stop_count;
    logic [3:0]  frame_bits;
    logic        bit_tick;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    uart_mode_router dut_i (
        .clk(clk), .rst_n(rst_n),
        .cfg_wr_en(cfg_wr_en), .cfg_wr_sel(cfg_wr_sel), .cfg_wr_data(cfg_wr_data),
        .host_wr_valid(host_wr_valid), .host_wr_byte(host_wr_byte),
        .line_rx_valid(line_rx_valid), .line_rx_byte(line_rx_byte),
        .rxq_valid(rxq_valid), .rxq_byte(rxq_byte),
        .txq_valid(txq_valid), .txq_byte(txq_byte),
        .rx_enabled(rx_enabled), .tx_enabled(tx_enabled),
        .break_req(break_req), .timeout_restart(timeout_restart),
        .rx_reset_pulse(rx_reset_pulse), .tx_reset_pulse(tx_reset_pulse),
        .chan_mode(chan_mode), .char_bits(char_bits),
        .parity_on(parity_on), .parity_odd(parity_odd),
        .stop_count(stop_count), .frame_bits(frame_bits),
        .bit_tick(bit_tick)
    );

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr_reg(logic [1:0] sel, logic [15:0] val);
        cfg_wr_en   = 1'b1;
        cfg_wr_sel  = sel;
        cfg_wr_data = val;
        step();
        cfg_wr_en   = 1'b0;
    endtask

    task automatic measure(output int period);
        int c;
        step();
        step();
        c = 0;
        while (!bit_tick && c < 4000) begin
            step();
            c++;
        end
        c = 0;
        do begin
            step();
            c++;
        end while (!bit_tick && c < 4000);
        period = c;
    endtask

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        int p;
        step();
        step();
        rst_n = 1'b1;
        step();

        // R1 reset state
        chk("R1 rx_enabled", rx_enabled, 0);
        chk("R1 tx_enabled", tx_enabled, 0);
        chk("R1 break_req", break_req, 0);
        chk("R1 chan_mode", chan_mode, 0);
        chk("R1 char_bits", char_bits, 8);
        chk("R1 parity_on", parity_on, 1);
        chk("R1 parity_odd", parity_odd, 0);
        chk("R1 stop_count", stop_count, 2);
        chk("R1 frame_bits", frame_bits, 12);
        chk("R1 rx_reset_pulse", rx_reset_pulse, 0);
        chk("R1 tx_reset_pulse", tx_reset_pulse, 0);
        measure(p);
        chk("R1 tick period", p, 15);

        // R2 self-clearing strobes
        wr_reg(2'd0, 16'h0001);
        chk("R2 rx strobe high", rx_reset_pulse, 1);
        chk("R2 tx strobe quiet", tx_reset_pulse, 0);
        step();
        chk("R2 rx strobe falls", rx_reset_pulse, 0);
        wr_reg(2'd0, 16'h0002);
        chk("R2 tx strobe high", tx_reset_pulse, 1);
        chk("R2 rx strobe quiet", rx_reset_pulse, 0);
        step();
        chk("R2 tx strobe falls", tx_reset_pulse, 0);
        wr_reg(2'd0, 16'h0003);
        chk("R2 both rx", rx_reset_pulse, 1);
        chk("R2 both tx", tx_reset_pulse, 1);
        step();
        chk("R2 both fall", {rx_reset_pulse, tx_reset_pulse}, 0);

        // R3 R4 R5 full control sweep
        for (int v = 0; v < 512; v++) begin
            logic [8:0] c9;
            c9 = 9'(v);
            wr_reg(2'd0, 16'(v));
            chk("R3 rx enable decode", rx_enabled, c9[2] & ~c9[3]);
            chk("R4 tx enable decode", tx_enabled, c9[4] & ~c9[5]);
            chk("R5 break decode", break_req, c9[7] & ~c9[8]);
            chk("R5 timeout level", timeout_restart, c9[6]);
        end

        // R6..R9 routing sweep
        for (int m = 0; m < 4; m++) begin
            wr_reg(2'd1, 16'(m << 8));
            for (int en = 0; en < 4; en++) begin
                wr_reg(2'd0, 16'(((en & 1) != 0 ? 4 : 0) | ((en & 2) != 0 ? 16 : 0)));
                for (int kind = 1; kind < 4; kind++) begin
                    logic hv, lv, erx, etx;
                    logic [7:0] hb, lb, erb, etb;
                    hv = (kind & 1) != 0;
                    lv = (kind & 2) != 0;
                    hb = 8'(8'hA0 + m * 16 + en * 4 + kind);
                    lb = 8'(8'h30 + m * 16 + en * 4 + kind);
                    erx = 0; etx = 0; erb = 0; etb = 0;
                    case (m)
                        0: begin
                            erx = lv && (en & 1) != 0; erb = lb;
                            etx = hv && (en & 2) != 0; etb = hb;
                        end
                        1: begin
                            erx = lv && (en & 1) != 0; erb = lb;
                            etx = lv && (en & 2) != 0; etb = lb;
                        end
                        2: begin
                            erx = hv && (en & 1) != 0; erb = hb;
                        end
                        default: begin
                            etx = lv && (en & 2) != 0; etb = lb;
                        end
                    endcase
                    host_wr_valid = hv; host_wr_byte = hb;
                    line_rx_valid = lv; line_rx_byte = lb;
                    step();
                    host_wr_valid = 0; line_rx_valid = 0;
                    if (m == 0) chk("R6 normal rx valid", rxq_valid, erx);
                    if (m == 0) chk("R6 normal tx valid", txq_valid, etx);
                    if (m == 1) chk("R7 echo rx valid", rxq_valid, erx);
                    if (m == 1) chk("R7 echo tx valid", txq_valid, etx);
                    if (m == 2) chk("R8 local rx valid", rxq_valid, erx);
                    if (m == 2) chk("R8 local tx valid", txq_valid, etx);
                    if (m == 3) chk("R9 remote rx valid", rxq_valid, erx);
                    if (m == 3) chk("R9 remote tx valid", txq_valid, etx);
                    if (erx) chk("R6 R7 R8 rx byte", rxq_byte, erb);
                    if (etx) chk("R6 R7 R9 tx byte", txq_byte, etb);
                    step();
                    chk("R6 single cycle valid", {rxq_valid, txq_valid}, 0);
                end
            end
        end

        // R10 R11 format sweep
        for (int m = 0; m < 256; m++) begin
            logic [7:0] mv;
            int eb, ep, es;
            mv = 8'(m);
            eb = (mv[2:1] == 2'd3) ? 6 : (mv[2:1] == 2'd2) ? 7 : 8;
            ep = (mv[5:3] <= 3'd1) ? 1 : 0;
            es = (mv[7:6] == 2'd3) ? 1 : 2;
            wr_reg(2'd1, 16'(m));
            chk("R10 data bits", char_bits, eb);
            chk("R10 parity on", parity_on, ep);
            chk("R10 parity odd", parity_odd, (mv[5:3] == 3'd1) ? 1 : 0);
            chk("R10 stop bits", stop_count, es);
            chk("R11 frame length", frame_bits, 1 + eb + ep + es);
        end

        // R12 tick periods
        wr_reg(2'd1, 16'h0000);
        wr_reg(2'd2, 16'd3); wr_reg(2'd3, 16'd1);
        measure(p); chk("R12 period 3x2", p, 6);
        wr_reg(2'd2, 16'd1); wr_reg(2'd3, 16'd0);
        measure(p); chk("R12 period 1", p, 1);
        wr_reg(2'd2, 16'd5); wr_reg(2'd3, 16'd2);
        measure(p); chk("R12 period 5x3", p, 15);
        wr_reg(2'd1, 16'h0001);
        wr_reg(2'd2, 16'd2); wr_reg(2'd3, 16'd0);
        measure(p); chk("R12 prescaled 8x2", p, 16);
        wr_reg(2'd2, 16'd1); wr_reg(2'd3, 16'd1);
        measure(p); chk("R12 prescaled 8x1x2", p, 16);

        // R13 zero generator
        wr_reg(2'd1, 16'h0000);
        wr_reg(2'd3, 16'd4);
        wr_reg(2'd2, 16'd0);
        begin
            int seen;
            seen = 0;
            for (int i = 0; i < 300; i++) begin
                step();
                if (bit_tick) seen++;
            end
            chk("R13 no tick with zero generator", seen, 0);
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule